// File: doc/BRIEF.md
# Load-Store Alignment and Byte-Lane Unit

This unit sits between a 64-bit register datapath and a byte-addressed data memory that is 64 bits wide. It accepts one load or store request per cycle. For each request it forms the effective address by adding a sign-extended 16-bit displacement to a base value. It then checks natural alignment for the requested size of 1, 2, 4 or 8 bytes. For an aligned request it drives a doubleword-aligned memory request one cycle later. A store also gets steered write data and per-lane byte enables. A load gets its result extracted and extended onto the register write port in the following cycle, when the synchronous memory returns its read data.

A mode bit, sampled with each request, selects little-endian or big-endian byte ordering. A misaligned request is not split into two accesses. It raises a flag for one cycle and touches neither memory nor the register file.

Top module: `lsu_lane_unit`

## Requirements
- R1: One cycle after a request, `mem_addr_o` carries the effective address base_i + sign_extend(disp_i), with its three low bits forced to zero.
- R2: `req_size_i` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A request whose effective address is not a multiple of its size raises `misalign_o` for exactly the next cycle, and any other request leaves it low.
- R3: A misaligned request asserts neither `mem_req_o` nor `mem_we_o`, produces no later `rf_we_o`, and leaves memory contents unchanged.
- R4: Memory lane j is `mem_be_o[j]` and `mem_wdata_o[8j+7:8j]`. In little-endian mode, byte address offset k (address bits 2:0) maps to lane k. In big-endian mode it maps to lane 7-k. A store enables exactly the lanes its bytes occupy. Loads drive no byte enables.
- R5: A store writes only the low N bytes of `store_data_i` (N = size). In little-endian mode the least significant byte goes to the lowest address. In big-endian mode the most significant of the N bytes goes there. Unenabled lanes carry zero.
- R6: For an aligned load, `rf_we_o` is high two cycles after the request, in the cycle `mem_rdata_i` answers the memory request. `rf_wdata_o` then holds the N addressed bytes assembled with the R4/R5 ordering, and it is zero whenever `rf_we_o` is low.
- R7: A 4-byte load with `req_unsigned_i` low fills result bits 63:32 with bit 31 of the loaded word.
- R8: 1- and 2-byte loads sign-extend when `req_unsigned_i` is low. When it is high, every load narrower than 8 bytes zero-extends.
- R9: `big_endian_i` is sampled per request, so consecutive requests may use different byte orders.
- R10: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code (R2) |
| req_unsigned_i | input | 1 | Zero-extend narrow loads |
| big_endian_i | input | 1 | Byte order for this request |
| base_i | input | 64 | Base register value |
| disp_i | input | 16 | Signed displacement |
| store_data_i | input | 64 | Store source register |
| mem_rdata_i | input | 64 | Memory read data, one cycle after a load request |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 64 | Doubleword-aligned memory address |
| mem_be_o | output | 8 | Per-lane write enables |
| mem_wdata_o | output | 64 | Lane-steered write data |
| misalign_o | output | 1 | Misaligned request flag |
| rf_we_o | output | 1 | Register write strobe for load results |
| rf_wdata_o | output | 64 | Extended load result |

## Verification
The bench drives each size at its extreme offsets in both byte orders. A lane map that ignored the mode bit, or reversed bytes instead of shifting the group, would put big-endian halfwords and bytes on the wrong lanes and read back swapped values. Words with bit 31 set, and bytes and halfwords with their top bit set, are loaded both signed and unsigned, so a stuck or swapped extension path shows up in the upper result bits. Misaligned stores are followed by aligned loads of the same doubleword, which exposes any write that leaked through. A displacement of 0x8000 against a base with high bits set catches an adder that zero-extends.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } lsu_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int LANES  = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  lsu_size_e         size_i,
  input  logic              big_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o,
  output logic [OFF_W-1:0]  lane_sh_o
);
  logic [OFF_W:0]   nbytes;
  logic [OFF_W:0]   sh_big;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] low_mask;

  assign ea_o     = base_i + {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign off      = ea_o[OFF_W-1:0];
  assign nbytes   = (OFF_W+1)'(1) << size_i;
  assign low_mask = OFF_W'(nbytes - (OFF_W+1)'(1));
  assign misalign_o = |(off & low_mask);

  // big-endian: byte group sits at the top of the lane range, mirrored
  assign sh_big    = (OFF_W+1)'(LANES) - {1'b0, off} - nbytes;
  assign lane_sh_o = big_i ? sh_big[OFF_W-1:0] : off;
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] data_i,
  input  lsu_size_e         size_i,
  input  logic [OFF_W-1:0]  lane_sh_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  logic [OFF_W:0]      nbytes;
  logic [LANES-1:0]    keep;
  logic [DATA_W-1:0]   data_m;

  assign nbytes = (OFF_W+1)'(1) << size_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign keep[k]           = (OFF_W+1)'(k) < nbytes;
    assign data_m[8*k +: 8]  = keep[k] ? data_i[8*k +: 8] : 8'h00;
  end

  assign wdata_o = data_m << {lane_sh_i, 3'b000};
  assign be_o    = keep << lane_sh_i;
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  lsu_size_e         size_i,
  input  logic [OFF_W-1:0]  lane_sh_i,
  input  logic              uns_i,
  output logic [DATA_W-1:0] value_o
);
  logic [DATA_W-1:0] aligned;

  assign aligned = rdata_i >> {lane_sh_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = {{(DATA_W-8){!uns_i && aligned[7]}},   aligned[7:0]};
      SZ_HALF: value_o = {{(DATA_W-16){!uns_i && aligned[15]}}, aligned[15:0]};
      SZ_WORD: value_o = {{(DATA_W-32){!uns_i && aligned[31]}}, aligned[31:0]};
      default: value_o = aligned;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_store_i,
  input  logic [1:0]          req_size_i,
  input  logic                req_unsigned_i,
  input  logic                big_endian_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [DATA_W-1:0]   store_data_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                misalign_o,
  output logic                rf_we_o,
  output logic [DATA_W-1:0]   rf_wdata_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  lsu_size_e         size_in;
  logic [ADDR_W-1:0] ea;
  logic              mis;
  logic [OFF_W-1:0]  lane_sh;
  logic [DATA_W-1:0] st_wdata;
  logic [LANES-1:0]  st_be;
  logic              acc_ok;

  assign size_in = lsu_size_e'(req_size_i);

  lsu_addr_gen #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .LANES(LANES)
  ) u_agen (
    .base_i    (base_i),
    .disp_i    (disp_i),
    .size_i    (size_in),
    .big_i     (big_endian_i),
    .ea_o      (ea),
    .misalign_o(mis),
    .lane_sh_o (lane_sh)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
    .data_i   (store_data_i),
    .size_i   (size_in),
    .lane_sh_i(lane_sh),
    .wdata_o  (st_wdata),
    .be_o     (st_be)
  );

  assign acc_ok = req_valid_i && !mis;

  // address phase
  logic              a_req_q, a_we_q, a_mis_q, a_uns_q;
  logic [ADDR_W-1:0] a_addr_q;
  logic [LANES-1:0]  a_be_q;
  logic [DATA_W-1:0] a_wdata_q;
  lsu_size_e         a_size_q;
  logic [OFF_W-1:0]  a_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_req_q   <= 1'b0;
      a_we_q    <= 1'b0;
      a_mis_q   <= 1'b0;
      a_uns_q   <= 1'b0;
      a_addr_q  <= '0;
      a_be_q    <= '0;
      a_wdata_q <= '0;
      a_size_q  <= SZ_BYTE;
      a_sh_q    <= '0;
    end else begin
      a_req_q   <= acc_ok;
      a_we_q    <= acc_ok && req_store_i;
      a_mis_q   <= req_valid_i && mis;
      a_uns_q   <= req_unsigned_i;
      a_addr_q  <= acc_ok ? {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : '0;
      a_be_q    <= (acc_ok && req_store_i) ? st_be : '0;
      a_wdata_q <= (acc_ok && req_store_i) ? st_wdata : '0;
      a_size_q  <= size_in;
      a_sh_q    <= lane_sh;
    end
  end

  // response phase: synchronous memory answers one cycle after the request
  logic             b_we_q, b_uns_q;
  lsu_size_e        b_size_q;
  logic [OFF_W-1:0] b_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_we_q   <= 1'b0;
      b_uns_q  <= 1'b0;
      b_size_q <= SZ_BYTE;
      b_sh_q   <= '0;
    end else begin
      b_we_q   <= a_req_q && !a_we_q;
      b_uns_q  <= a_uns_q;
      b_size_q <= a_size_q;
      b_sh_q   <= a_sh_q;
    end
  end

  logic [DATA_W-1:0] ld_val;

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .rdata_i  (mem_rdata_i),
    .size_i   (b_size_q),
    .lane_sh_i(b_sh_q),
    .uns_i    (b_uns_q),
    .value_o  (ld_val)
  );

  assign mem_req_o   = a_req_q;
  assign mem_we_o    = a_we_q;
  assign mem_addr_o  = a_addr_q;
  assign mem_be_o    = a_be_q;
  assign mem_wdata_o = a_wdata_q;
  assign misalign_o  = a_mis_q;
  assign rf_we_o     = b_we_q;
  assign rf_wdata_o  = b_we_q ? ld_val : '0;
endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic                misalign_o,
  input logic                rf_we_o
);
  assert_misalign_blocks_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && !mem_we_o));

  assert_no_rf_after_misalign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !rf_we_o);

  assert_store_lane_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                  $countones(mem_be_o) == 4 || $countones(mem_be_o) == 8));

  assert_load_no_be_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_be_o == '0));

  assert_write_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  assert_rf_follows_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_req_o && !mem_we_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!mem_req_o && !misalign_o));
endmodule

bind lsu_lane_unit lsu_lane_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_be_o   (mem_be_o),
  .misalign_o (misalign_o),
  .rf_we_o    (rf_we_o)
);

// File: tb/tb_lsu_lane_unit.sv
`timescale 1ns/1ps
module tb_lsu_lane_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_unsigned_i = 1'b0, big_endian_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic [63:0] base_i = '0, store_data_i = '0;
  logic [15:0] disp_i = '0;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, rf_we_o;
  logic [63:0] mem_addr_o, mem_wdata_o, rf_wdata_o;
  logic [7:0]  mem_be_o;

  always #10 clk_i = ~clk_i;

  lsu_lane_unit dut (.*);

  typedef struct {
    logic req, we, mis, rfwe;
    logic [63:0] addr, wdata, rfd;
    logic [7:0] be;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // memory as physical lanes; ref_m mirrors it from the requirements
  logic [63:0] dmem [0:15];
  logic [7:0]  ref_m [0:127];

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 3) ^ (i << 4));
  endfunction

  initial begin
    for (int k = 0; k < 16; k++)
      for (int j = 0; j < 8; j++) begin
        dmem[k][8*j +: 8] = pat(k*8 + j);
        ref_m[k*8 + j]    = pat(k*8 + j);
      end
  end

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int j = 0; j < 8; j++)
          if (mem_be_o[j]) dmem[mem_addr_o[6:3]][8*j +: 8] <= mem_wdata_o[8*j +: 8];
      end else begin
        mem_rdata_i <= dmem[mem_addr_o[6:3]];
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    item_t it;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    it = '{req:0, we:0, mis:0, rfwe:0, addr:0, wdata:0, rfd:0, be:0, tag:"R6"};
    q.push_back(it);
  endtask

  task automatic issue(logic st, logic [1:0] sz, logic uns, logic big,
                       logic [63:0] base, logic [15:0] disp, logic [63:0] data, string tag);
    item_t it;
    logic [63:0] ea, a, val;
    int n, lane;
    logic [7:0] b;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = st; req_size_i = sz; req_unsigned_i = uns;
    big_endian_i = big; base_i = base; disp_i = disp; store_data_i = data;
    ea = base + {{48{disp[15]}}, disp};
    n  = 1 << sz;
    it = '{req:0, we:0, mis:0, rfwe:0, addr:0, wdata:0, rfd:0, be:0, tag:tag};
    if ((ea % n) != 0) begin
      it.mis = 1;
    end else begin
      it.req  = 1;
      it.addr = {ea[63:3], 3'b000};
      val = '0;
      for (int i = 0; i < n; i++) begin
        a    = ea + i;
        lane = big ? 7 - int'(a[2:0]) : int'(a[2:0]);
        if (st) begin
          b = big ? data[8*(n-1-i) +: 8] : data[8*i +: 8];
          it.be[lane] = 1'b1;
          it.wdata[8*lane +: 8] = b;
          ref_m[{a[6:3], 3'(lane)}] = b;
        end else begin
          b = ref_m[{a[6:3], 3'(lane)}];
          if (big) val = (val << 8) | 64'(b);
          else     val = val | (64'(b) << (8*i));
        end
      end
      if (st) it.we = 1;
      else begin
        if (n < 8 && !uns && val[8*n-1]) val = val | ~((64'd1 << (8*n)) - 64'd1);
        it.rfwe = 1;
        it.rfd  = val;
      end
    end
    q.push_back(it);
  endtask

  // monitor: address phase of item k, result phase of item k-1
  initial begin
    item_t cur, pend;
    pend = '{req:0, we:0, mis:0, rfwe:0, addr:0, wdata:0, rfd:0, be:0, tag:"R6"};
    @(posedge rst_ni);
    forever begin
      @(posedge clk_i); #5;
      if (q.size() > 0) cur = q.pop_front();
      else cur = '{req:0, we:0, mis:0, rfwe:0, addr:0, wdata:0, rfd:0, be:0, tag:"R6"};
      chk("R1 mem_addr", mem_addr_o, cur.addr);
      chk("R2 misalign", 64'(misalign_o), 64'(cur.mis));
      chk("R3 mem_req", 64'(mem_req_o), 64'(cur.req));
      chk("R3 mem_we", 64'(mem_we_o), 64'(cur.we));
      chk("R4 mem_be", 64'(mem_be_o), 64'(cur.be));
      chk("R5 mem_wdata", mem_wdata_o, cur.wdata);
      chk("R6 rf_we", 64'(rf_we_o), 64'(pend.rfwe));
      chk({pend.tag, " rf_wdata"}, rf_wdata_o, pend.rfd);
      pend = cur;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #25;
    // R10: reset state
    chk("R10 mem_req", 64'(mem_req_o), 0);
    chk("R10 mem_we", 64'(mem_we_o), 0);
    chk("R10 mem_be", 64'(mem_be_o), 0);
    chk("R10 misalign", 64'(misalign_o), 0);
    chk("R10 rf_we", 64'(rf_we_o), 0);
    chk("R10 rf_wdata", rf_wdata_o, 0);
    chk("R10 mem_addr", mem_addr_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // little-endian doubleword round trip (R5, R6)
    issue(1, 2'd3, 0, 0, 64'h40, 16'h0, 64'h1122334455667788, "R5");
    issue(0, 2'd3, 0, 0, 64'h40, 16'h0, 0, "R6");
    // word at offset 4 with bit 31 set (R5, R7, R8)
    issue(1, 2'd2, 0, 0, 64'h48, 16'h4, 64'hDEADBEEF80000001, "R5");
    issue(0, 2'd2, 0, 0, 64'h48, 16'h4, 0, "R7");
    issue(0, 2'd2, 1, 0, 64'h48, 16'h4, 0, "R8");
    // big-endian halfword, read in both orders (R9)
    issue(1, 2'd1, 0, 1, 64'h50, 16'h2, 64'h000000000000ABCD, "R5");
    issue(0, 2'd1, 0, 1, 64'h50, 16'h2, 0, "R9");
    issue(0, 2'd1, 0, 0, 64'h50, 16'h2, 0, "R9");
    issue(0, 2'd1, 1, 1, 64'h50, 16'h2, 0, "R8");
    // bytes at the edge offsets (R4, R8)
    issue(1, 2'd0, 0, 1, 64'h58, 16'h7, 64'hFFFFFFFFFFFFFF90, "R4");
    issue(0, 2'd0, 0, 1, 64'h58, 16'h7, 0, "R8");
    issue(0, 2'd0, 1, 1, 64'h58, 16'h7, 0, "R8");
    issue(0, 2'd0, 0, 0, 64'h58, 16'h0, 0, "R8");
    issue(1, 2'd0, 0, 0, 64'h58, 16'h3, 64'h7F, "R4");
    issue(0, 2'd0, 0, 0, 64'h58, 16'h3, 0, "R6");
    // big-endian doubleword and word (R5, R9)
    issue(1, 2'd3, 0, 1, 64'h60, 16'h0, 64'h0102030405060708, "R5");
    issue(0, 2'd3, 0, 1, 64'h60, 16'h0, 0, "R9");
    issue(0, 2'd3, 0, 0, 64'h60, 16'h0, 0, "R9");
    issue(0, 2'd2, 0, 1, 64'h60, 16'h4, 0, "R7");
    // misaligned stores and loads, then reads of the same doubleword (R2, R3)
    issue(1, 2'd1, 0, 0, 64'h68, 16'h1, 64'hFFFF, "R3");
    issue(1, 2'd2, 0, 1, 64'h68, 16'h2, 64'hFFFFFFFF, "R3");
    issue(1, 2'd3, 0, 0, 64'h68, 16'h4, 64'h5A5A5A5A5A5A5A5A, "R3");
    issue(0, 2'd3, 0, 0, 64'h6C, 16'h0, 0, "R3");
    issue(0, 2'd3, 0, 0, 64'h68, 16'h0, 0, "R3");
    idle();
    // displacement sign extension (R1)
    issue(0, 2'd2, 0, 0, 64'h1078, 16'hFFF0, 0, "R1");
    issue(1, 2'd3, 0, 0, 64'hFFFF000000008040, 16'h8000, 64'hCAFEF00D12345678, "R1");
    issue(0, 2'd3, 0, 0, 64'h40, 16'h0, 0, "R1");
    // back-to-back order switch on one doubleword (R9)
    issue(1, 2'd1, 0, 0, 64'h70, 16'h6, 64'h8001, "R9");
    issue(0, 2'd1, 0, 1, 64'h70, 16'h0, 0, "R9");
    for (int i = 0; i < 4; i++) idle();
    repeat (2) @(posedge clk_i);
    #6;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule